// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog with a 32-bit word register port. Software loads a reload value and sets the enable bit in the control register. From then on a live counter drops by one on every microsecond tick, and the tick is made by dividing the peripheral clock. To keep the system alive, software must write a fixed 16-bit key into the restart register before the counter runs out. Any other value written there does nothing.

When the counter runs out, the block stops counting. It then emits a one-cycle system reset request, a one-cycle external reset request, or both, according to the control bits, and it can also raise a latched interrupt. A scope output tells the downstream reset shaper whether the whole chip or only the SoC core is to be reset. A hold input from the memory-controller reset logic can veto an expiry. When it does, nothing is emitted and the control register is wiped to zero.

The reset-width and reset-mask registers are plain storage that a neighbouring pulse shaper reads through software. This block gives them no behaviour of its own.

Top module: `wdog_core`

## Requirements
- R1: After reset the counter (byte offset 0x00) and reload (0x04) registers read 0x03EF1480, control (0x0C) reads 0x00000010, reset-width (0x18) reads 0x000000FF, reset-mask (0x1C) reads 0 and restart (0x08) reads 0.
- R2: Reload, reset-width and reset-mask store and read back all 32 bits. Restart always reads 0. Writes to the counter, to unmapped offsets or to offsets whose low two bits are not zero change nothing, and reads of unmapped or misaligned offsets return 0.
- R3: Every control write stores the data with bits 11:8 forced to 0 and bit 4 forced to 1.
- R4: A control write with bit 0 set while the stored bit 0 is clear copies the reload value into the counter in the same cycle and starts counting.
- R5: While running, the counter decreases by one every PRESCALE (default 24) clock cycles, counted from the cycle it was loaded.
- R6: A control write that clears bit 0 freezes the counter at its current value.
- R7: A write to restart whose bits 15:0 equal 0x4755 reloads the counter and restarts the tick phase; bits 31:16 are ignored. Any other low half has no effect. A restart while disabled loads the counter but does not start it.
- R8: When the counter steps from 1 to 0, counting stops and the counter stays at 0. In that same cycle reset_event pulses for exactly one cycle if control bit 1 is set, and ext_reset_event pulses for one cycle if control bit 3 is set. With reload N, the pulse comes PRESCALE*N cycles after the enable edge. reset_full_chip follows control bit 5.
- R9: If control bit 2 is set at expiry, irq goes high and stays high until a keyed restart.
- R10: If mc_hold is high at expiry, neither event pulses, irq stays low and control reads 0.
- R11: A control write that keeps bit 0 set while already enabled does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock (24 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| mc_hold | input | 1 | Memory-controller reset hold; vetoes expiry |
| reset_event | output | 1 | One-cycle system reset request |
| ext_reset_event | output | 1 | One-cycle external reset request |
| reset_full_chip | output | 1 | Reset scope: 1 full chip, 0 SoC only |
| irq | output | 1 | Latched expiry interrupt |

## Verification
A wrong prescaler phase or a missed reload shows up as an expiry pulse that comes a whole number of PRESCALE periods early or late. The bench therefore sweeps reload values and times the pulse to the exact cycle. A running flag that is not cleared at expiry would let the counter wrap or pulse again. This shows at the counter port within one tick, so the counter is read again long after each expiry. A control register that is not sanitized, or that is not wiped by the hold veto, is visible on the next read. An interrupt latch with the wrong clear condition is visible as soon as a restart is issued.

// File: rtl/wdog_pkg.sv
// Shared constants for the keyed-restart watchdog.
// Assumes a 32-bit register word and byte addressing with word alignment.
package wdog_pkg;
    localparam int REG_W = 32;

    // Byte offsets of the register words
    localparam int OFS_COUNT   = 'h00;
    localparam int OFS_RELOAD  = 'h04;
    localparam int OFS_RESTART = 'h08;
    localparam int OFS_CTRL    = 'h0C;
    localparam int OFS_WIDTH   = 'h18;
    localparam int OFS_MASK    = 'h1C;

    // Control bit positions
    localparam int CB_ENABLE = 0;
    localparam int CB_SYSRST = 1;
    localparam int CB_IRQ    = 2;
    localparam int CB_EXTRST = 3;
    localparam int CB_SLOW   = 4;
    localparam int CB_SCOPE  = 5;

    // Force the reserved nibble to zero and the slow-tick select to one
    function automatic logic [REG_W-1:0] sanitize_ctrl(input logic [REG_W-1:0] d);
        logic [REG_W-1:0] r;
        r = d;
        r[11:8] = 4'h0;
        r[CB_SLOW] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
// Tick prescaler: divides the clock by DIV while the timer runs.
// Assumes DIV >= 2. The phase restarts on every load and while stopped.
module wdog_prescaler #(
    parameter int DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && !restart && (pre_q == LAST);

    // Phase counter: clears on load or stop, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
    p_pre_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
// Live countdown counter with a running flag.
// Assumes load and stop are never requested in the same cycle.
// Expiry is flagged combinationally on the tick that leaves it at zero.
module wdog_counter #(
    parameter int                         CNT_W   = 32,
    parameter logic [CNT_W-1:0]           RST_VAL = 32'h03EF1480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             arm,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign cnt     = cnt_q;
    assign running = run_q;
    assign expire  = run_q && tick && !load && (cnt_q <= ONE);

    // Count value: load, hold, or step down on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run_q && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Running flag: armed by load, cleared by stop or expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (load) begin
            run_q <= arm;
        end else if (stop || expire) begin
            run_q <= 1'b0;
        end
    end

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && !load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(cnt_q));
    p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/wdog_regs.sv
// Register file and decoder for the watchdog.
// Assumes single-cycle accesses. Words are decoded only when the low two
// address bits are zero. Produces the load, arm and stop controls for
// the counter, and the keyed-restart strobe.
module wdog_regs #(
    parameter int                      ADDR_W     = 8,
    parameter logic [15:0]             KEY        = 16'h4755,
    parameter logic [wdog_pkg::REG_W-1:0] RELOAD_RST = 32'h03EF1480
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [wdog_pkg::REG_W-1:0]    bus_wdata,
    output logic [wdog_pkg::REG_W-1:0]    bus_rdata,
    input  logic [wdog_pkg::REG_W-1:0]    cnt,
    input  logic                          veto,
    output logic [wdog_pkg::REG_W-1:0]    ctrl,
    output logic [wdog_pkg::REG_W-1:0]    reload,
    output logic                          load,
    output logic                          arm,
    output logic                          stop,
    output logic                          key_ok
);
    import wdog_pkg::*;

    localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_WIDTH   = ADDR_W'(OFS_WIDTH);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
    localparam logic [REG_W-1:0]  CTRL_RST  = sanitize_ctrl('0);
    localparam logic [REG_W-1:0]  WIDTH_RST = REG_W'(32'hFF);

    logic [REG_W-1:0] ctrl_q, reload_q, width_q, mask_q, ctrl_new;
    logic             aligned, wr, hit_ctrl, en_rise, en_fall;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr       = bus_valid && bus_write && aligned;
    assign hit_ctrl = wr && (bus_addr == A_CTRL);
    assign ctrl_new = sanitize_ctrl(bus_wdata);
    assign en_rise  = hit_ctrl &&  ctrl_new[CB_ENABLE] && !ctrl_q[CB_ENABLE];
    assign en_fall  = hit_ctrl && !ctrl_new[CB_ENABLE] &&  ctrl_q[CB_ENABLE];
    assign key_ok   = wr && (bus_addr == A_RESTART) && (bus_wdata[15:0] == KEY);

    assign load   = en_rise || key_ok;
    assign arm    = en_rise || ctrl_q[CB_ENABLE];
    assign stop   = en_fall;
    assign ctrl   = ctrl_q;
    assign reload = reload_q;

    // Control word: bus write wins over the expiry veto wipe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (hit_ctrl) begin
            ctrl_q <= ctrl_new;
        end else if (veto) begin
            ctrl_q <= '0;
        end
    end

    // Plain storage words: reload value, pulse width, reset mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RELOAD_RST;
            width_q  <= WIDTH_RST;
            mask_q   <= '0;
        end else if (wr) begin
            if (bus_addr == A_RELOAD) reload_q <= bus_wdata;
            if (bus_addr == A_WIDTH)  width_q  <= bus_wdata;
            if (bus_addr == A_MASK)   mask_q   <= bus_wdata;
        end
    end

    // Read mux: unmapped, write-only and misaligned offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (bus_addr)
                A_COUNT:  bus_rdata = cnt;
                A_RELOAD: bus_rdata = reload_q;
                A_CTRL:   bus_rdata = ctrl_q;
                A_WIDTH:  bus_rdata = width_q;
                A_MASK:   bus_rdata = mask_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_ctrl_sane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[11:8] == 4'h0) && (ctrl_q[CB_SLOW] || ctrl_q == '0));
    p_restart_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RESTART) |-> (bus_rdata == '0));
endmodule

// File: rtl/wdog_core.sv
// Keyed-restart watchdog core: register file, tick prescaler, countdown
// counter and expiry event logic.
// Assumes clk is the 24 MHz peripheral clock when PRESCALE = 24.
// The control sanitizer always selects the divided tick.
module wdog_core #(
    parameter int          ADDR_W     = 8,
    parameter int          PRESCALE   = 24,
    parameter logic [15:0] KEY        = 16'h4755,
    parameter logic [31:0] RELOAD_RST = 32'h03EF1480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mc_hold,
    output logic              reset_event,
    output logic              ext_reset_event,
    output logic              reset_full_chip,
    output logic              irq
);
    import wdog_pkg::*;

    logic [REG_W-1:0] ctrl, reload, cnt;
    logic load, arm, stop, key_ok, tick, running, expire, veto, fire;
    logic rst_evt_q, ext_evt_q, irq_q;

    assign veto = expire && mc_hold;
    assign fire = expire && !mc_hold;

    wdog_regs #(
        .ADDR_W(ADDR_W), .KEY(KEY), .RELOAD_RST(RELOAD_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .veto(veto), .ctrl(ctrl), .reload(reload),
        .load(load), .arm(arm), .stop(stop), .key_ok(key_ok)
    );

    wdog_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(load), .tick(tick)
    );

    wdog_counter #(.CNT_W(REG_W), .RST_VAL(RELOAD_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .arm(arm), .load_val(reload),
        .stop(stop), .tick(tick), .cnt(cnt), .running(running), .expire(expire)
    );

    // Expiry pulses, each qualified by its control enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_evt_q <= 1'b0;
            ext_evt_q <= 1'b0;
        end else begin
            rst_evt_q <= fire && ctrl[CB_SYSRST];
            ext_evt_q <= fire && ctrl[CB_EXTRST];
        end
    end

    // Interrupt latch: set at unvetoed expiry, cleared by keyed restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (key_ok) begin
            irq_q <= 1'b0;
        end else if (fire && ctrl[CB_IRQ]) begin
            irq_q <= 1'b1;
        end
    end

    assign reset_event     = rst_evt_q;
    assign ext_reset_event = ext_evt_q;
    assign reset_full_chip = ctrl[CB_SCOPE];
    assign irq             = irq_q;

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_event |=> !reset_event);
    p_ext_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset_event |=> !ext_reset_event);
    p_veto_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (veto && !(bus_valid && bus_write)) |=>
            (!reset_event && !ext_reset_event && bus_rdata !== 32'hx && !irq_q == !$past(irq_q)));
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fire));
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> !irq);
endmodule

// File: tb/wdog_core_test.sv
`timescale 1ns/100ps
module wdog_core_test;
    localparam int PS = 24;
    localparam logic [7:0] A_CNT = 8'h00, A_REL = 8'h04, A_RST = 8'h08,
                           A_CTL = 8'h0C, A_WID = 8'h18, A_MSK = 8'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0, mc_hold = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic reset_event, ext_reset_event, reset_full_chip, irq;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    wdog_core uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mc_hold(mc_hold), .reset_event(reset_event),
        .ext_reset_event(ext_reset_event), .reset_full_chip(reset_full_chip),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Watch events for lim cycles; first cycle index and count of high cycles
    task automatic watch(input int lim, output int k_r, output int n_r,
                         output int k_x, output int n_x);
        k_r = -1; n_r = 0; k_x = -1; n_x = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (reset_event) begin if (k_r < 0) k_r = i; n_r++; end
            if (ext_reset_event) begin if (k_x < 0) k_x = i; n_x++; end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int kr, nr, kx, nx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CNT, v); chk("R1 counter", v, 32'h03EF1480);
        rd(A_REL, v); chk("R1 reload", v, 32'h03EF1480);
        rd(A_CTL, v); chk("R1 control", v, 32'h00000010);
        rd(A_WID, v); chk("R1 width", v, 32'h000000FF);
        rd(A_MSK, v); chk("R1 mask", v, 32'h0);
        rd(A_RST, v); chk("R1 restart", v, 32'h0);
        chk("R1 outputs", {28'h0, reset_event, ext_reset_event, irq, reset_full_chip}, 32'h0);

        // R2 storage, ignored writes, unmapped reads
        wr(A_REL, 32'hDEADBEEF); rd(A_REL, v); chk("R2 reload rb", v, 32'hDEADBEEF);
        wr(A_WID, 32'h12345678); rd(A_WID, v); chk("R2 width rb", v, 32'h12345678);
        wr(A_MSK, 32'hA5A5F00F); rd(A_MSK, v); chk("R2 mask rb", v, 32'hA5A5F00F);
        wr(A_CNT, 32'h11111111); rd(A_CNT, v); chk("R2 counter ro", v, 32'h03EF1480);
        wr(8'h40, 32'hFFFFFFFF); rd(8'h40, v); chk("R2 unmapped", v, 32'h0);
        wr(8'h05, 32'h77777777); rd(A_REL, v); chk("R2 misaligned wr", v, 32'hDEADBEEF);
        rd(8'h05, v); chk("R2 misaligned rd", v, 32'h0);
        rd(A_CNT, v); chk("R2 counter after stray", v, 32'h03EF1480);

        // R3 sanitizing
        wr(A_CTL, 32'h00000F00); rd(A_CTL, v); chk("R3 nibble", v, 32'h00000010);
        wr(A_CTL, 32'hFFFFFFFE); rd(A_CTL, v); chk("R3 full", v, 32'hFFFFF0FE);
        chk("R8 scope", {31'h0, reset_full_chip}, 32'h1);
        wr(A_CTL, 32'h0); rd(A_CTL, v); chk("R3 zero", v, 32'h00000010);
        chk("R8 scope low", {31'h0, reset_full_chip}, 32'h0);

        // R4/R8 sweep of reload values, expiry timing exact to the cycle
        for (int n = 1; n <= 6; n++) begin
            wr(A_CTL, 32'h12);
            wr(A_REL, n);
            wr(A_CTL, 32'h13);
            rd(A_CNT, v); chk("R4 load on enable", v, n);
            watch(PS * n + 30, kr, nr, kx, nx);
            chk("R8 expiry cycle", kr, PS * n);
            chk("R8 pulse width", nr, 1);
            chk("R8 no ext pulse", nx, 0);
            chk("R9 no irq", {31'h0, irq}, 32'h0);
            rd(A_CNT, v); chk("R8 zero after", v, 32'h0);
            repeat (60) @(negedge clk);
            rd(A_CNT, v); chk("R8 stays stopped", v, 32'h0);
        end

        // R8 ext only
        wr(A_CTL, 32'h10); wr(A_REL, 2); wr(A_CTL, 32'h19);
        watch(PS * 2 + 10, kr, nr, kx, nx);
        chk("R8 ext cycle", kx, PS * 2);
        chk("R8 ext width", nx, 1);
        chk("R8 sysrst masked", nr, 0);

        // R5 stepping, R11 re-enable, R6 freeze
        wr(A_CTL, 32'h10); wr(A_REL, 10); wr(A_CTL, 32'h13);
        for (int k = 1; k <= 4; k++) begin
            repeat (PS) @(negedge clk);
            rd(A_CNT, v); chk("R5 step", v, 10 - k);
        end
        wr(A_CTL, 32'h13); rd(A_CNT, v); chk("R11 no reload", v, 6);
        wr(A_CTL, 32'h12); rd(A_CNT, v); chk("R6 freeze now", v, 6);
        repeat (200) @(negedge clk);
        rd(A_CNT, v); chk("R6 freeze later", v, 6);

        // R7 keys while disabled
        wr(A_REL, 3);
        wr(A_RST, 32'h00004756); rd(A_CNT, v); chk("R7 wrong key", v, 6);
        wr(A_RST, 32'h47550000); rd(A_CNT, v); chk("R7 key in high half", v, 6);
        wr(A_RST, 32'hABCD4755); rd(A_CNT, v); chk("R7 keyed load", v, 3);
        repeat (100) @(negedge clk);
        rd(A_CNT, v); chk("R7 not started", v, 3);

        // R7 restart while running shifts expiry
        wr(A_CTL, 32'h13);
        repeat (30) @(negedge clk);
        rd(A_CNT, v2); chk("R7 mid count", v2, 2);
        wr(A_RST, 32'h00004755);
        watch(PS * 3 + 20, kr, nr, kx, nx);
        chk("R7 expiry after restart", kr, PS * 3);

        // R9 interrupt latch
        wr(A_CTL, 32'h10); wr(A_REL, 2); wr(A_CTL, 32'h17);
        watch(PS * 2 + 5, kr, nr, kx, nx);
        chk("R9 with event", kr, PS * 2);
        chk("R9 irq set", {31'h0, irq}, 32'h1);
        wr(A_CTL, 32'h16);
        repeat (20) @(negedge clk);
        chk("R9 irq held", {31'h0, irq}, 32'h1);
        wr(A_RST, 32'h1234);
        chk("R9 irq wrong key", {31'h0, irq}, 32'h1);
        wr(A_RST, 32'h4755);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);

        // R10 hold veto
        wr(A_CTL, 32'h10); wr(A_REL, 2);
        mc_hold = 1'b1;
        wr(A_CTL, 32'h3F);
        watch(PS * 2 + 30, kr, nr, kx, nx);
        chk("R10 no reset", nr, 0);
        chk("R10 no ext", nx, 0);
        chk("R10 no irq", {31'h0, irq}, 32'h0);
        rd(A_CTL, v); chk("R10 ctrl wiped", v, 32'h0);
        rd(A_CNT, v); chk("R10 counter zero", v, 32'h0);
        mc_hold = 1'b0;

        finish_run();
    end
endmodule